// File: doc/BRIEF.md
# Packetising Byte-to-Word Stream Transmitter

The block accepts a packet one byte at a time, with a flag on the final byte, and sends it out as wide beats on a valid/ready streaming interface. Every beat holds several byte lanes. The first beat of a packet is flagged as the start and the beat holding the last byte is flagged as the end. On the end beat, a count reports how many lanes are unused. A channel number is taken with the first byte of each packet and is shown on every beat of that packet. A packet that asks for a channel above the configured maximum is consumed and thrown away, and the block raises a one-cycle error pulse.

The downstream side applies backpressure with zero ready latency. A beat stays on the bus, unchanged, until it is taken. A pair of configuration inputs sets a traffic-shaping pattern: after a chosen number of beats, valid is held low for a chosen number of cycles. An idle count of zero turns shaping off.

Top module: `stx_pkt_packer`

## Requirements
- R1: Each beat carries BYTES byte lanes. With HIGH_FIRST=1 (the default), byte k of a beat sits in bits [(BYTES-1-k)*8 +: 8]. With HIGH_FIRST=0 it sits in bits [k*8 +: 8]. Unused lanes read zero.
- R2: st_sop is high only on the first beat of a packet.
- R3: st_eop is high only on the beat holding the final byte. On that beat st_empty equals BYTES minus the number of bytes in the beat. On every other beat st_empty is 0.
- R4: While st_valid is high and st_ready is low, the beat (valid, data, sop, eop, empty, channel) stays unchanged in the next cycle.
- R5: When no beat is offered, st_valid, st_sop, st_eop, st_empty, st_chan and st_data are all zero.
- R6: The channel is sampled with the first byte of a packet and shown on every beat of that packet. It never exceeds MAX_CHAN.
- R7: If the channel given with a packet's first byte exceeds MAX_CHAN, chan_err is high for the single cycle after that byte is accepted. All bytes of that packet are accepted and no beat is produced for it.
- R8: With cfg_off nonzero, after every cfg_on beats (0 counts as 1) no beat is offered until cfg_off cycles after the handshake cycle. With unbroken input and a ready sink, the interval between handshakes is max(cfg_off, BYTES)+1 cycles after such a beat and BYTES+1 otherwise. cfg_off = 0 inserts no gaps.
- R9: in_ready is low while a complete beat waits. Otherwise one byte is accepted per cycle. The cycle after a handshake never offers a beat.
- R10: After reset: st_valid low, in_ready high, chan_err low, st_chan 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the packet |
| in_chan | input | CH_W | Requested channel, taken with the first byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| cfg_on | input | CNT_W | Beats between idle gaps |
| cfg_off | input | CNT_W | Idle cycles per gap, 0 disables gaps |
| st_valid | output | 1 | Beat offered |
| st_ready | input | 1 | Sink takes the beat (zero latency) |
| st_data | output | BYTES*8 | Beat data |
| st_sop | output | 1 | First beat of packet |
| st_eop | output | 1 | Last beat of packet |
| st_empty | output | $clog2(BYTES) | Unused lanes on the last beat |
| st_chan | output | CH_W | Packet channel |
| chan_err | output | 1 | Pulse: packet dropped for channel out of range |

## Verification
A wrong lane count or a stale start/end flag shows up on the very beat it affects. It appears as misplaced or extra bytes, a missing end flag, or a wrong empty count, and it is seen at the handshake where the scoreboard pops the expected beat. A stuck drop state shows as missing beats and a surplus of error pulses, which the drain check at the end exposes. A gap counter that is off by one changes the measured handshake spacing in the first shaped interval.

// File: rtl/stx_pkg.sv
package stx_pkg;
    // Fill collects bytes, hold offers a finished beat, drop discards a rejected packet
    typedef enum logic [1:0] {
        MODE_FILL = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_DROP = 2'd2
    } stx_mode_e;
endpackage

// File: rtl/stx_lane_put.sv
module stx_lane_put #(
    parameter int BYTES      = 4,
    parameter bit HIGH_FIRST = 1'b1,
    localparam int W         = BYTES * 8,
    localparam int IW        = $clog2(BYTES + 1)
) (
    input  logic [7:0]    byte_in,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  acc_in,
    output logic [W-1:0]  acc_out
);
    for (genvar l = 0; l < BYTES; l++) begin : g_lane
        if (HIGH_FIRST) begin : g_hi
            localparam int POS = BYTES - 1 - l;
            assign acc_out[POS*8 +: 8] = (idx == IW'(l)) ? byte_in : acc_in[POS*8 +: 8];
        end else begin : g_lo
            assign acc_out[l*8 +: 8] = (idx == IW'(l)) ? byte_in : acc_in[l*8 +: 8];
        end
    end
endmodule

// File: rtl/stx_gap_ctl.sv
module stx_gap_ctl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [CNT_W-1:0] cfg_on,
    input  logic [CNT_W-1:0] cfg_off,
    output logic             hold
);
    typedef struct packed {
        logic [CNT_W-1:0] on;
        logic [CNT_W-1:0] off;
    } gap_t;

    gap_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (g_q.off != '0) begin
            g_d.off = g_q.off - 1'b1;
        end
        if (fire) begin
            if (cfg_off == '0) begin
                g_d.on = '0;
            end else if (({1'b0, g_q.on} + (CNT_W+1)'(1)) >= {1'b0, cfg_on}) begin
                g_d.on  = '0;
                g_d.off = cfg_off;
            end else begin
                g_d.on = g_q.on + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign hold = (g_q.off != '0);
endmodule

// File: rtl/stx_pkt_packer.sv
module stx_pkt_packer #(
    parameter int BYTES      = 4,
    parameter int CH_W       = 2,
    parameter int MAX_CHAN   = (1 << CH_W) - 1,
    parameter bit HIGH_FIRST = 1'b1,
    parameter int CNT_W      = 8,
    localparam int W         = BYTES * 8,
    localparam int EW        = $clog2(BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [CH_W-1:0]  in_chan,
    output logic             in_ready,
    input  logic [CNT_W-1:0] cfg_on,
    input  logic [CNT_W-1:0] cfg_off,
    output logic             st_valid,
    input  logic             st_ready,
    output logic [W-1:0]     st_data,
    output logic             st_sop,
    output logic             st_eop,
    output logic [EW-1:0]    st_empty,
    output logic [CH_W-1:0]  st_chan,
    output logic             chan_err
);
    import stx_pkg::*;

    localparam int CW = $clog2(BYTES + 1);
    localparam logic [CW-1:0]   BYTES_C = CW'(BYTES);
    localparam logic [CH_W-1:0] MAXC    = CH_W'(MAX_CHAN);

    typedef struct packed {
        stx_mode_e        mode;
        logic [W-1:0]     acc;
        logic [CW-1:0]    cnt;
        logic             first;
        logic             sop;
        logic             eop;
        logic [CH_W-1:0]  chan;
        logic             err;
    } pk_t;

    pk_t s_d, s_q;

    logic [W-1:0]  acc_put;
    logic          gap_hold;
    logic          offer;
    logic          fire;
    logic          take;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] empty_full;

    stx_lane_put #(
        .BYTES      (BYTES),
        .HIGH_FIRST (HIGH_FIRST)
    ) u_put (
        .byte_in (in_data),
        .idx     (s_q.cnt),
        .acc_in  (s_q.acc),
        .acc_out (acc_put)
    );

    stx_gap_ctl #(
        .CNT_W (CNT_W)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .cfg_on  (cfg_on),
        .cfg_off (cfg_off),
        .hold    (gap_hold)
    );

    assign in_ready = (s_q.mode != MODE_HOLD);
    assign offer    = (s_q.mode == MODE_HOLD) && !gap_hold;
    assign fire     = offer && st_ready;
    assign take     = in_valid && in_ready;
    assign cnt_inc  = s_q.cnt + CW'(1);

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (fire) begin
            s_d.mode = MODE_FILL;
            s_d.acc  = '0;
            s_d.cnt  = '0;
            s_d.sop  = 1'b0;
            s_d.eop  = 1'b0;
        end
        if (take) begin
            if (s_q.mode == MODE_DROP) begin
                if (in_last) begin
                    s_d.mode  = MODE_FILL;
                    s_d.first = 1'b1;
                end
            end else if (s_q.first && (in_chan > MAXC)) begin
                s_d.err = 1'b1;
                if (!in_last) begin
                    s_d.mode = MODE_DROP;
                end
            end else begin
                s_d.acc = acc_put;
                s_d.cnt = cnt_inc;
                if (s_q.first) begin
                    s_d.sop   = 1'b1;
                    s_d.chan  = in_chan;
                    s_d.first = 1'b0;
                end
                if (in_last) begin
                    s_d.first = 1'b1;
                end
                if ((cnt_inc == BYTES_C) || in_last) begin
                    s_d.mode = MODE_HOLD;
                    s_d.eop  = in_last;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.mode  <= MODE_FILL;
            s_q.first <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign empty_full = BYTES_C - s_q.cnt;
    assign st_valid   = offer;
    assign st_data    = offer ? s_q.acc : '0;
    assign st_sop     = offer && s_q.sop;
    assign st_eop     = offer && s_q.eop;
    assign st_empty   = (offer && s_q.eop) ? empty_full[EW-1:0] : '0;
    assign st_chan    = offer ? s_q.chan : '0;
    assign chan_err   = s_q.err;
endmodule

// File: rtl/stx_pkt_packer_chk.sv
module stx_pkt_packer_chk #(
    parameter int BYTES    = 4,
    parameter int CH_W     = 2,
    parameter int MAX_CHAN = 3,
    localparam int W       = BYTES * 8,
    localparam int EW      = $clog2(BYTES)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_ready,
    input logic            st_valid,
    input logic            st_ready,
    input logic [W-1:0]    st_data,
    input logic            st_sop,
    input logic            st_eop,
    input logic [EW-1:0]   st_empty,
    input logic [CH_W-1:0] st_chan
);
    localparam logic [CH_W-1:0] MAXC = CH_W'(MAX_CHAN);

    // R4
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_sop)
            && $stable(st_eop) && $stable(st_empty) && $stable(st_chan));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |-> !st_sop && !st_eop && st_empty == '0 && st_chan == '0 && st_data == '0);

    // R3
    empty_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_eop |-> st_empty == '0);

    // R6
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> st_chan <= MAXC);

    // R9
    no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> !in_ready);

    // R9
    beat_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready |=> !st_valid && in_ready);
endmodule

bind stx_pkt_packer stx_pkt_packer_chk #(
    .BYTES    (BYTES),
    .CH_W     (CH_W),
    .MAX_CHAN (MAX_CHAN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .st_data  (st_data),
    .st_sop   (st_sop),
    .st_eop   (st_eop),
    .st_empty (st_empty),
    .st_chan  (st_chan)
);

// File: tb/sim_stx_pkt_packer.sv
`timescale 1ns/1ps
module sim_stx_pkt_packer;
    localparam int BYTES = 4;
    localparam int CHW   = 2;
    localparam int MAXC  = 2;
    localparam int CNTW  = 8;

    typedef struct packed {
        logic [31:0] data;
        logic        sop;
        logic        eop;
        logic [1:0]  empty;
        logic [1:0]  chan;
    } beat_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_last = 1'b0;
    logic [CHW-1:0] in_chan = '0;
    logic [CNTW-1:0] cfg_on = '0;
    logic [CNTW-1:0] cfg_off = '0;
    logic st_ready = 1'b0;
    logic in_ready, in_ready1;
    logic st_valid, st_sop, st_eop, chan_err;
    logic [31:0] st_data;
    logic [1:0] st_empty, st_chan;
    logic v1, sop1, eop1, err1;
    logic [31:0] data1;
    logic [1:0] empty1, chan1;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rdy_pct = 100;
    int exp_err = 0;
    int err_seen = 0;
    bit done = 0;
    bit prev_hold = 0;
    logic [31:0] prev_data = '0;
    beat_t exp_q[$];
    int fire_q[$];

    always #2 clk = ~clk;

    stx_pkt_packer #(.BYTES(BYTES), .CH_W(CHW), .MAX_CHAN(MAXC), .HIGH_FIRST(1'b1), .CNT_W(CNTW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_chan(in_chan), .in_ready(in_ready), .cfg_on(cfg_on), .cfg_off(cfg_off),
        .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .st_sop(st_sop),
        .st_eop(st_eop), .st_empty(st_empty), .st_chan(st_chan), .chan_err(chan_err));

    stx_pkt_packer #(.BYTES(BYTES), .CH_W(CHW), .MAX_CHAN(MAXC), .HIGH_FIRST(1'b0), .CNT_W(CNTW)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_chan(in_chan), .in_ready(in_ready1), .cfg_on(cfg_on), .cfg_off(cfg_off),
        .st_valid(v1), .st_ready(st_ready), .st_data(data1), .st_sop(sop1),
        .st_eop(eop1), .st_empty(empty1), .st_chan(chan1), .chan_err(err1));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] swap_lanes(input logic [31:0] d);
        logic [31:0] r;
        for (int k = 0; k < BYTES; k++) r[k*8 +: 8] = d[(BYTES-1-k)*8 +: 8];
        return r;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always begin
        @(posedge clk);
        #1;
        st_ready = (($urandom % 100) < rdy_pct);
    end

    // Monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (chan_err) err_seen++;
            if (prev_hold) begin
                check(st_valid && st_data == prev_data, "R4", "held beat", {31'd0, st_valid, st_data}, {31'd1, prev_data});
            end
            prev_hold = st_valid && !st_ready;
            prev_data = st_data;
            if (st_valid) begin
                check(!in_ready, "R9", "in_ready while beat waits", in_ready, 0);
            end else begin
                check(!st_sop && !st_eop && st_empty == 0 && st_chan == 0 && st_data == 0, "R5", "idle outputs",
                      {st_sop, st_eop, st_empty, st_chan, st_data}, 0);
            end
            if (st_valid && st_ready) begin
                fire_q.push_back(cyc);
                check(v1 && data1 == swap_lanes(st_data), "R1", "low-first lane order", data1, swap_lanes(st_data));
                if (exp_q.size() == 0) begin
                    check(0, "R7", "unexpected beat", st_data, 0);
                end else begin
                    beat_t e;
                    beat_t a;
                    e = exp_q.pop_front();
                    a = '{data: st_data, sop: st_sop, eop: st_eop, empty: st_empty, chan: st_chan};
                    check(a.data == e.data, "R1", "beat data", a.data, e.data);
                    check(a.sop == e.sop, "R2", "sop", a.sop, e.sop);
                    check(a.eop == e.eop && a.empty == e.empty, "R3", "eop/empty",
                          {a.eop, a.empty}, {e.eop, e.empty});
                    check(a.chan == e.chan, "R6", "channel", a.chan, e.chan);
                end
            end
        end
    end

    task automatic push(input logic [7:0] b, input bit last, input int ch);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = last;
        in_chan  = CHW'(ch);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_pkt(input int len, input int ch, input int idle_pct);
        logic [7:0] b[64];
        bit bad;
        bad = (ch > MAXC);
        for (int i = 0; i < len; i++) b[i] = 8'($urandom);
        if (bad) begin
            exp_err++;
        end else begin
            for (int s = 0; s < len; s += BYTES) begin
                beat_t e;
                int nb;
                nb = ((len - s) < BYTES) ? (len - s) : BYTES;
                e = '0;
                for (int k = 0; k < nb; k++) e.data[(BYTES-1-k)*8 +: 8] = b[s+k];
                e.sop   = (s == 0);
                e.eop   = (s + BYTES >= len);
                e.empty = e.eop ? 2'(BYTES - nb) : 2'd0;
                e.chan  = 2'(ch);
                exp_q.push_back(e);
            end
        end
        for (int i = 0; i < len; i++) begin
            if (idle_pct > 0 && ($urandom % 100) < idle_pct) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            push(b[i], (i == len - 1), ch);
            if (bad && i == 0) begin
                @(negedge clk);
                check(chan_err == 1'b1, "R7", "error pulse after first byte", chan_err, 1);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic gap_run(input int on, input int off, input int len, input int e0, input int e1, input int e2);
        int exp_iv[3];
        exp_iv[0] = e0; exp_iv[1] = e1; exp_iv[2] = e2;
        cfg_on  = CNTW'(on);
        cfg_off = CNTW'(off);
        idle(25);
        fire_q.delete();
        send_pkt(len, 1, 0);
        idle(30);
        check(fire_q.size() == len / BYTES, "R8", "beat count in shaped run", fire_q.size(), len / BYTES);
        for (int i = 1; i < fire_q.size() && i <= 3; i++) begin
            check(fire_q[i] - fire_q[i-1] == exp_iv[i-1], "R8", "handshake spacing",
                  fire_q[i] - fire_q[i-1], exp_iv[i-1]);
        end
    endtask

    initial begin
        #(4 * 150000);
        check(0, "R9", "watchdog expired", cyc, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        rdy_pct = 100;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!st_valid && in_ready && !chan_err && st_chan == 0, "R10", "reset state",
              {st_valid, in_ready, chan_err, st_chan}, 5'b01000);

        // Directed: single byte, full beat, beat plus one, bad channel
        send_pkt(1, 1, 0);
        send_pkt(4, 2, 0);
        send_pkt(5, 0, 0);
        send_pkt(6, 3, 0);
        send_pkt(1, 3, 0);
        send_pkt(3, 2, 0);
        idle(10);
        check(exp_q.size() == 0, "R7", "directed beats drained", exp_q.size(), 0);

        // R8 shaping: off disabled, every beat, every second beat
        gap_run(3, 0, 16, 5, 5, 5);
        gap_run(1, 10, 12, 11, 11, 0);
        gap_run(2, 8, 16, 5, 9, 5);
        gap_run(0, 2, 12, 5, 5, 0);

        // Random traffic with backpressure and shaping
        rdy_pct = 60;
        for (int p = 0; p < 150; p++) begin
            if (($urandom % 4) == 0) begin
                cfg_on  = CNTW'($urandom % 4);
                cfg_off = (($urandom % 2) == 0) ? '0 : CNTW'(1 + $urandom % 6);
            end
            send_pkt(1 + $urandom % 13, $urandom % 4, 20);
        end
        rdy_pct = 100;
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        idle(20);
        check(exp_q.size() == 0, "R3", "all packets delivered", exp_q.size(), 0);
        check(err_seen == exp_err, "R7", "error pulse count", err_seen, exp_err);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule